// File: doc/BRIEF.md
# Programmable baud tick interrupt generator

This block produces the baud-rate tick for one serial channel and turns those ticks into interrupt state. Two byte-wide control inputs together form a 16-bit divisor. A start strobe arms the generator with the divisor present at that moment. From then on the block emits a one-cycle tick every divisor clock cycles. After each tick it reloads from the divisor inputs as they stand then, so a new divisor applies from the next period. A divisor of zero, whether seen at a start or at a reload, halts the generator until a later start with a nonzero divisor.

Every tick is remembered. When both the tick interrupt enable and the external/status interrupt enable are set, the tick raises the external/status interrupt and consumes the tick-pending flag. Otherwise the tick leaves the tick-pending flag set, so software that enables the interrupt later can still see that an earlier tick happened. A clear strobe drops both flags.

Top module: `baud_tick_irq`

## Requirements
- R1: After reset, `tick`, `tick_pend` and `ext_irq` are 0 and no tick occurs until `gen_start` is pulsed with a nonzero divisor.
- R2: With divisor N (N >= 1), the first `tick` is high N clock edges after the edge that samples `gen_start`, and later ticks follow every N cycles; with N = 1 `tick` stays high every cycle.
- R3: The divisor is `{div_hi, div_lo}`: `div_hi` gives bits 15:8 and `div_lo` gives bits 7:0.
- R4: A `gen_start` that samples a zero divisor stops the generator, also one that is already running; after that no tick occurs until a start with a nonzero divisor.
- R5: At each tick the counter reloads from the divisor inputs present in that cycle. A change made after a tick therefore sets the length of the period after the current one. If the divisor is zero at a reload, that tick is still emitted and the generator then stops.
- R6: A tick while `tick_ie` and `ext_ie` are not both 1 sets `tick_pend` and leaves `ext_irq` unchanged. `tick_pend` and `ext_irq` never rise without a tick.
- R7: A tick while `tick_ie` and `ext_ie` are both 1 sets `ext_irq` and clears `tick_pend`.
- R8: Setting the enables does not raise `ext_irq` on its own; an earlier tick stays visible on `tick_pend` until the next tick or a clear.
- R9: A `clr` pulse clears `tick_pend` and `ext_irq` on the next edge. When a tick occurs on the same edge, the tick's update wins.
- R10: A `gen_start` while running restarts the count, so the next tick comes N cycles after the new start. For N > 1 each tick pulse is one cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_hi | input | 8 | Divisor bits 15:8 |
| div_lo | input | 8 | Divisor bits 7:0 |
| gen_start | input | 1 | One-cycle strobe that arms the generator with the current divisor |
| tick_ie | input | 1 | Tick interrupt enable |
| ext_ie | input | 1 | External/status interrupt enable |
| clr | input | 1 | One-cycle strobe that clears both pending flags |
| tick | output | 1 | One-cycle tick pulse |
| tick_pend | output | 1 | Tick seen but not turned into an interrupt |
| ext_irq | output | 1 | External/status interrupt request |

## Verification
The divider is run with divisors of 1, 5 and 259. The last value has both bytes nonzero, which shows that the two bytes are joined in the right order. The 1 case shows the continuous-tick edge of the counter. Divisor changes made just after a tick show that the reload uses the new value one period later rather than immediately, and a zero loaded either by a start or at a reload shows that both ways of halting work. The interrupt side is tried with neither enable, with only one enable, with both, and with the enables raised after a tick. It also covers a clear that coincides with a tick, which distinguishes the priority of a tick over a clear.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

    typedef enum logic {
        GEN_IDLE = 1'b0,
        GEN_RUN  = 1'b1
    } gen_state_e;

    typedef struct packed {
        logic tick_pend;
        logic ext_pend;
    } pend_t;

endpackage

// File: rtl/baud_div_src.sv
module baud_div_src #(
    parameter int BYTE_W = 8,
    localparam int DIV_W = 2 * BYTE_W
) (
    input  logic [BYTE_W-1:0] hi_byte,
    input  logic [BYTE_W-1:0] lo_byte,
    output logic [DIV_W-1:0]  reload_val,
    output logic              div_zero
);

    logic [DIV_W-1:0] divisor;

    always_comb begin
        divisor    = {hi_byte, lo_byte};
        div_zero   = (divisor == '0);
        reload_val = divisor - DIV_W'(1);
    end

endmodule

// File: rtl/baud_div_cnt.sv
module baud_div_cnt
    import baud_tick_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] reload_val,
    input  logic             div_zero,
    output logic             tick_evt,
    output logic             tick
);

    typedef struct packed {
        gen_state_e       run;
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        tick_evt  = 1'b0;
        if (start) begin
            if (div_zero) begin
                st_d.run = GEN_IDLE;
                st_d.cnt = '0;
            end else begin
                st_d.run = GEN_RUN;
                st_d.cnt = reload_val;
            end
        end else if (st_q.run == GEN_RUN) begin
            if (st_q.cnt == '0) begin
                tick_evt  = 1'b1;
                st_d.tick = 1'b1;
                if (div_zero) begin
                    st_d.run = GEN_IDLE;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = reload_val;
                end
            end else begin
                st_d.cnt = st_q.cnt - DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{run: GEN_IDLE, cnt: '0, tick: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;

endmodule

// File: rtl/baud_pend_ctl.sv
module baud_pend_ctl
    import baud_tick_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_evt,
    input  logic tick_ie,
    input  logic ext_ie,
    input  logic clr,
    output logic tick_pend,
    output logic ext_pend
);

    pend_t pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (clr) begin
            pend_d.tick_pend = 1'b0;
            pend_d.ext_pend  = 1'b0;
        end
        if (tick_evt) begin
            if (tick_ie && ext_ie) begin
                pend_d.ext_pend  = 1'b1;
                pend_d.tick_pend = 1'b0;
            end else begin
                pend_d.tick_pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '{tick_pend: 1'b0, ext_pend: 1'b0};
        end else begin
            pend_q <= pend_d;
        end
    end

    assign tick_pend = pend_q.tick_pend;
    assign ext_pend  = pend_q.ext_pend;

endmodule

// File: rtl/baud_tick_irq.sv
module baud_tick_irq #(
    parameter int BYTE_W = 8,
    localparam int DIV_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] div_hi,
    input  logic [BYTE_W-1:0] div_lo,
    input  logic              gen_start,
    input  logic              tick_ie,
    input  logic              ext_ie,
    input  logic              clr,
    output logic              tick,
    output logic              tick_pend,
    output logic              ext_irq
);

    logic [DIV_W-1:0] reload_val;
    logic             div_zero;
    logic             tick_evt;

    baud_div_src #(.BYTE_W(BYTE_W)) i_src (
        .hi_byte    (div_hi),
        .lo_byte    (div_lo),
        .reload_val (reload_val),
        .div_zero   (div_zero)
    );

    baud_div_cnt #(.DIV_W(DIV_W)) i_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (gen_start),
        .reload_val (reload_val),
        .div_zero   (div_zero),
        .tick_evt   (tick_evt),
        .tick       (tick)
    );

    baud_pend_ctl i_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_evt  (tick_evt),
        .tick_ie   (tick_ie),
        .ext_ie    (ext_ie),
        .clr       (clr),
        .tick_pend (tick_pend),
        .ext_pend  (ext_irq)
    );

endmodule

// File: rtl/baud_tick_irq_chk.sv
module baud_tick_irq_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BYTE_W-1:0] div_hi,
    input logic [BYTE_W-1:0] div_lo,
    input logic              gen_start,
    input logic              tick_ie,
    input logic              ext_ie,
    input logic              clr,
    input logic              tick,
    input logic              tick_pend,
    input logic              ext_irq
);

    logic stopped_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stopped_q <= 1'b1;
        end else if (gen_start) begin
            stopped_q <= ({div_hi, div_lo} == '0);
        end
    end

    // R4
    idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stopped_q |-> !tick);

    // R6
    tick_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !$past(tick_ie && ext_ie)) |-> tick_pend);

    // R7
    ext_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && $past(tick_ie && ext_ie)) |-> (ext_irq && !tick_pend));

    // R9
    clr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && $past(clr)) |-> (!tick_pend && !ext_irq));

    // R6
    pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tick_pend) |-> tick);

    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_irq) |-> tick);

endmodule

bind baud_tick_irq baud_tick_irq_chk #(.BYTE_W(BYTE_W)) i_chk (.*);

// File: tb/test_baud_tick_irq.sv
module test_baud_tick_irq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_hi = '0;
    logic [7:0] div_lo = '0;
    logic       gen_start = 1'b0;
    logic       tick_ie = 1'b0;
    logic       ext_ie = 1'b0;
    logic       clr = 1'b0;
    logic       tick;
    logic       tick_pend;
    logic       ext_irq;

    int total = 0;
    int bad = 0;
    int wd = 0;

    always #4 clk = ~clk;

    baud_tick_irq i_baud_tick_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_hi    (div_hi),
        .div_lo    (div_lo),
        .gen_start (gen_start),
        .tick_ie   (tick_ie),
        .ext_ie    (ext_ie),
        .clr       (clr),
        .tick      (tick),
        .tick_pend (tick_pend),
        .ext_irq   (ext_irq)
    );

    always @(negedge clk) begin
        wd++;
        if (wd > 190000) begin
            bad++;
            total++;
            $display("FAIL watchdog: act=%0d exp<190000", wd);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic set_div(input int n);
        div_hi = 8'((n >> 8) & 255);
        div_lo = 8'(n & 255);
    endtask

    task automatic pulse_start();
        @(negedge clk) gen_start = 1'b1;
        @(negedge clk) gen_start = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
    endtask

    // negedges until tick seen, max+1 when none
    task automatic wait_tick(input int max, output int k);
        k = 0;
        while (k <= max) begin
            @(negedge clk);
            k++;
            if (tick) return;
        end
    endtask

    task automatic halt();
        set_div(0);
        pulse_start();
        tick_ie = 1'b0;
        ext_ie = 1'b0;
        pulse_clr();
    endtask

    task automatic t_reset();
        int k;
        check("R1 tick in reset", int'(tick), 0);
        check("R1 tick_pend in reset", int'(tick_pend), 0);
        check("R1 ext_irq in reset", int'(ext_irq), 0);
        @(negedge clk) rst_n = 1'b1;
        set_div(3);
        wait_tick(50, k);
        check("R1 no tick before start", k, 51);
    endtask

    task automatic t_period();
        int k;
        set_div(5);
        pulse_start();
        wait_tick(100, k);
        check("R2 first tick div5", k, 5);
        @(negedge clk);
        check("R10 tick one cycle wide", int'(tick), 0);
        wait_tick(100, k);
        check("R2 second period div5", k, 4);
        wait_tick(100, k);
        check("R2 third period div5", k, 5);
        set_div(1);
        pulse_start();
        wait_tick(10, k);
        check("R2 first tick div1", k, 1);
        wait_tick(10, k);
        check("R2 continuous tick div1", k, 1);
        set_div(259);
        pulse_start();
        wait_tick(1000, k);
        check("R3 div hi=1 lo=3", k, 259);
        halt();
    endtask

    task automatic t_zero();
        int k;
        set_div(4);
        pulse_start();
        wait_tick(20, k);
        check("R4 runs before stop", k, 4);
        set_div(0);
        pulse_start();
        set_div(4);
        wait_tick(100, k);
        check("R4 zero start stops", k, 101);
        set_div(3);
        pulse_start();
        wait_tick(20, k);
        check("R4 restart after stop", k, 3);
        halt();
    endtask

    task automatic t_reload();
        int k;
        set_div(6);
        pulse_start();
        wait_tick(20, k);
        check("R5 first div6", k, 6);
        set_div(9);
        wait_tick(20, k);
        check("R5 current period kept", k, 6);
        wait_tick(20, k);
        check("R5 new divisor next period", k, 9);
        set_div(0);
        wait_tick(20, k);
        check("R5 last tick before zero stop", k, 9);
        set_div(2);
        wait_tick(60, k);
        check("R5 stopped by zero reload", k, 61);
        halt();
    endtask

    task automatic t_pend();
        int k;
        set_div(4);
        pulse_start();
        wait_tick(20, k);
        check("R6 tick_pend no enables", int'(tick_pend), 1);
        check("R6 ext_irq no enables", int'(ext_irq), 0);
        tick_ie = 1'b1;
        ext_ie = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R8 enable alone no irq", int'(ext_irq), 0);
        check("R8 earlier tick kept", int'(tick_pend), 1);
        wait_tick(20, k);
        check("R7 ext_irq both enabled", int'(ext_irq), 1);
        check("R7 tick_pend consumed", int'(tick_pend), 0);
        ext_ie = 1'b0;
        wait_tick(20, k);
        check("R6 tick_pend only tick_ie", int'(tick_pend), 1);
        check("R6 ext_irq unchanged", int'(ext_irq), 1);
        pulse_clr();
        check("R9 clr tick_pend", int'(tick_pend), 0);
        check("R9 clr ext_irq", int'(ext_irq), 0);
        tick_ie = 1'b0;
        ext_ie = 1'b1;
        wait_tick(20, k);
        check("R6 tick_pend only ext_ie", int'(tick_pend), 1);
        check("R6 ext_irq only ext_ie", int'(ext_irq), 0);
        halt();
    endtask

    task automatic t_clr_tick();
        int k;
        set_div(1);
        pulse_start();
        wait_tick(10, k);
        pulse_clr();
        check("R9 tick wins over clr", int'(tick_pend), 1);
        halt();
        check("R9 clr when idle", int'(tick_pend), 0);
    endtask

    task automatic t_restart();
        int k;
        set_div(8);
        pulse_start();
        repeat (3) @(negedge clk);
        pulse_start();
        wait_tick(20, k);
        check("R10 restart count", k, 8);
        halt();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_period();
        t_zero();
        t_reload();
        t_pend();
        t_clr_tick();
        t_restart();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule